// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block is the transmit half of an Ethernet DMA. Software builds a ring of two-word descriptors in memory, each pointing at a buffer and giving its length and flags. Software then enables the engine and writes the start bit. The engine walks the ring from the current queue position. For each frame it reads the referenced buffers through a simple memory master and streams their bytes out as one frame, with start and end markers on the byte stream.

A frame is one or more descriptors, closed by the one carrying the last-buffer flag. When a frame is fully streamed, the engine writes its first descriptor's status word back with the used flag set and raises a sticky done flag. It then moves on to the next frame. Processing halts at a descriptor whose used flag is already set. If that happens inside a frame, the frame is reported as exhausted mid-frame. A downstream underrun indication aborts the current frame, and the failure is recorded in the first descriptor.

Top module: `tx_desc_engine`

## Requirements
- R1: After reset, no memory request and no byte is presented, and the status word reads zero.
- R2: Descriptor i sits at queue base + 8*i. Word 0 holds the word-aligned buffer byte address. Word 1 is status: bit 31 used, bit 30 wrap, bit 15 last buffer of frame, bits 10:0 buffer length in bytes.
- R3: A control write with bit 9 (start) and bit 3 (enable) both set launches processing, but only if enable was already set and the engine is idle. A start written while disabled has no effect.
- R4: Buffer bytes leave in address order, with the lowest byte lane of each 32-bit word first, and only when the sink is ready. The buffers of a frame are concatenated, and a zero-length buffer contributes nothing. The first byte of a frame carries the start marker and the final byte of the last-flagged buffer carries the end marker.
- R5: After the final byte of a frame, the first descriptor's status word is written back unchanged except that bit 31 is set. Once that write is accepted, status bit 5 (done) becomes 1.
- R6: After a completed frame the engine fetches the next descriptor. A used descriptor at a frame boundary stops the engine silently, and the pointer stays on that descriptor.
- R7: The pointer advances by 8 bytes after each consumed descriptor, and returns to the queue base after one that has the wrap flag.
- R8: A used descriptor met inside a frame stops streaming without an end marker. The first descriptor's status is written back with bits 31 and 27 set, done stays 0, and the pointer returns to the queue base.
- R9: An underrun indication during a frame stops the byte stream in the same cycle. The first descriptor's status is written back with bits 31 and 28 set, done stays 0, and the pointer returns to the queue base.
- R10: Writing the status word with bit 5 set clears done. Writing it with bit 5 clear leaves done unchanged. A completion in the same cycle wins over the clear.
- R11: Clearing enable through a control write stops the engine at once, emits no further byte and returns the pointer to the queue base.
- R12: A memory request keeps its address and direction unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write data: bit 3 enable, bit 9 start |
| q_base | input | AW | Queue base byte address (8-byte aligned) |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 32 | Status write data: bit 5 clears done |
| sts_rdata | output | 32 | Status word: bit 5 done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte present |
| tx_ready | input | 1 | Sink takes the byte |
| tx_data | output | 8 | Frame byte |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Final byte of frame |
| mac_underrun | input | 1 | Downstream ran dry during the current frame |

## Verification
The assertions take three things for granted about the inputs. The queue base stays fixed while the engine is enabled. Memory eventually acknowledges every request. Software never clears enable in the same cycle that an acknowledge arrives. The stimulus keeps the base constant for the whole run and acknowledges every request within two cycles. Enable is toggled only while the engine sits idle. Every last-flagged buffer has a non-zero length, buffer addresses are word aligned, and underrun is raised only inside a frame, after fewer bytes than the frame holds.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned LEN_W    = 11;
    localparam int unsigned DESC_B   = 8;

    localparam int unsigned F_USED   = 31;
    localparam int unsigned F_WRAP   = 30;
    localparam int unsigned F_UNDR   = 28;
    localparam int unsigned F_EXH    = 27;
    localparam int unsigned F_LAST   = 15;

    localparam int unsigned CTL_EN   = 3;
    localparam int unsigned CTL_GO   = 9;
    localparam int unsigned STS_DONE = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_STAT,
        S_RD_ADDR,
        S_RD_BUF,
        S_SEND,
        S_WB
    } txd_state_e;

    typedef enum logic [1:0] {
        WB_OK,
        WB_EXH,
        WB_UNDR
    } wb_kind_e;

    function automatic logic [WORD_W-1:0] wb_word(input logic [WORD_W-1:0] orig,
                                                  input wb_kind_e kind);
        logic [WORD_W-1:0] w;
        w = orig;
        w[F_USED] = 1'b1;
        if (kind == WB_EXH)  w[F_EXH]  = 1'b1;
        if (kind == WB_UNDR) w[F_UNDR] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/txd_qptr.sv
module txd_qptr #(
    parameter int unsigned AW   = 32,
    parameter int unsigned STEP = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] base,
    input  logic          reload,
    input  logic          step,
    input  logic          wrap,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)         ptr <= '0;
        else if (reload) ptr <= base;
        else if (step)   ptr <= wrap ? base : ptr + AW'(STEP);
    end
endmodule

// File: rtl/txd_ser.sv
module txd_ser #(
    parameter int unsigned NB = 4,
    parameter int unsigned CW = $clog2(NB + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [8*NB-1:0] word,
    input  logic [CW-1:0]   count,
    input  logic            pop,
    input  logic            flush,
    output logic [7:0]      byte_o,
    output logic            avail,
    output logic            last_one
);
    logic [8*NB-1:0] word_q;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            word_q <= word;
            cnt_q  <= count;
        end else if (pop && cnt_q != '0) begin
            word_q <= word_q >> 8;
            cnt_q  <= cnt_q - CW'(1);
        end
    end

    assign byte_o   = word_q[7:0];
    assign avail    = (cnt_q != '0);
    assign last_one = (cnt_q == CW'(1));

    // R4
    cnt_le_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(NB));
endmodule

// File: rtl/txd_done.sv
module txd_done (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic done
);
    always_ff @(posedge clk) begin
        if (rst)      done <= 1'b0;
        else if (set) done <= 1'b1;
        else if (clr) done <= 1'b0;
    end
endmodule

// File: rtl/tx_desc_engine.sv
module tx_desc_engine
    import txd_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [31:0]       ctl_wdata,
    input  logic [AW-1:0]     q_base,
    input  logic              sts_wr,
    input  logic [31:0]       sts_wdata,
    output logic [31:0]       sts_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_sof,
    output logic              tx_eof,
    input  logic              mac_underrun
);
    localparam int unsigned NB = WORD_W / 8;
    localparam int unsigned CW = $clog2(NB + 1);

    txd_state_e        state;
    wb_kind_e          wb_kind;
    logic              en_q;
    logic [AW-1:0]     buf_addr;
    logic [LEN_W-1:0]  rem;
    logic              cur_last;
    logic              wrap_q;
    logic              in_frame;
    logic [AW-1:0]     first_ptr;
    logic [WORD_W-1:0] first_stat;
    logic              sof_pend;
    logic              uf_q;

    logic [AW-1:0]     ptr;
    logic              ser_avail;
    logic              ser_last;
    logic [7:0]        ser_byte;
    logic              done;
    logic [CW-1:0]     take;

    logic start, dis, abort, fire, buf_done, ptr_reload, wb_ok_ack;
    logic unused_bits;

    assign unused_bits = ^{ctl_wdata, sts_wdata};

    assign dis       = ctl_wr && !ctl_wdata[CTL_EN];
    assign start     = ctl_wr && ctl_wdata[CTL_GO] && ctl_wdata[CTL_EN] && en_q && state == S_IDLE;
    assign abort     = in_frame && (uf_q || mac_underrun);
    assign tx_valid  = (state == S_SEND) && ser_avail && !abort;
    assign fire      = tx_valid && tx_ready;
    assign tx_data   = ser_byte;
    assign tx_sof    = tx_valid && sof_pend;
    assign tx_eof    = tx_valid && cur_last && (rem == '0) && ser_last;
    assign wb_ok_ack = (state == S_WB) && mem_ack && (wb_kind == WB_OK);

    always_comb begin
        take = (rem >= LEN_W'(NB)) ? CW'(NB) : rem[CW-1:0];
    end

    assign buf_done = !dis && (rem == '0) && !abort &&
                      (((state == S_RD_ADDR) && mem_ack) ||
                       ((state == S_SEND) && !ser_avail));

    assign ptr_reload = !en_q || ((state == S_WB) && mem_ack && (wb_kind != WB_OK));

    // Memory master
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        unique case (state)
            S_RD_STAT: begin mem_req = 1'b1; mem_addr = ptr + AW'(4); end
            S_RD_ADDR: begin mem_req = 1'b1; mem_addr = ptr; end
            S_RD_BUF:  begin mem_req = 1'b1; mem_addr = buf_addr; end
            S_WB:      begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = first_ptr + AW'(4); end
            default:   ;
        endcase
    end
    assign mem_wdata = wb_word(first_stat, wb_kind);

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            state      <= S_IDLE;
            wb_kind    <= WB_OK;
            buf_addr   <= '0;
            rem        <= '0;
            cur_last   <= 1'b0;
            wrap_q     <= 1'b0;
            in_frame   <= 1'b0;
            first_ptr  <= '0;
            first_stat <= '0;
            sof_pend   <= 1'b0;
            uf_q       <= 1'b0;
        end else begin
            if (ctl_wr) en_q <= ctl_wdata[CTL_EN];
            if (fire) sof_pend <= 1'b0;
            if (mac_underrun && in_frame && state != S_WB) uf_q <= 1'b1;
            if (dis) begin
                state    <= S_IDLE;
                in_frame <= 1'b0;
                uf_q     <= 1'b0;
                sof_pend <= 1'b0;
            end else begin
                unique case (state)
                    S_IDLE: if (start) state <= S_RD_STAT;
                    S_RD_STAT: if (mem_ack) begin
                        if (abort) begin
                            wb_kind <= WB_UNDR;
                            state   <= S_WB;
                        end else if (mem_rdata[F_USED]) begin
                            if (in_frame) begin
                                wb_kind <= WB_EXH;
                                state   <= S_WB;
                            end else begin
                                state <= S_IDLE;
                            end
                        end else begin
                            if (!in_frame) begin
                                in_frame   <= 1'b1;
                                first_ptr  <= ptr;
                                first_stat <= mem_rdata;
                                sof_pend   <= 1'b1;
                            end
                            cur_last <= mem_rdata[F_LAST];
                            wrap_q   <= mem_rdata[F_WRAP];
                            rem      <= mem_rdata[LEN_W-1:0];
                            state    <= S_RD_ADDR;
                        end
                    end
                    S_RD_ADDR: if (mem_ack) begin
                        if (abort) begin
                            wb_kind <= WB_UNDR;
                            state   <= S_WB;
                        end else begin
                            buf_addr <= AW'(mem_rdata) & ~AW'(3);
                            if (rem != '0) begin
                                state <= S_RD_BUF;
                            end else begin
                                wb_kind <= WB_OK;
                                state   <= cur_last ? S_WB : S_RD_STAT;
                            end
                        end
                    end
                    S_RD_BUF: if (mem_ack) begin
                        if (abort) begin
                            wb_kind <= WB_UNDR;
                            state   <= S_WB;
                        end else begin
                            rem      <= rem - LEN_W'(take);
                            buf_addr <= buf_addr + AW'(NB);
                            state    <= S_SEND;
                        end
                    end
                    S_SEND: begin
                        if (abort) begin
                            wb_kind <= WB_UNDR;
                            state   <= S_WB;
                        end else if (!ser_avail) begin
                            if (rem != '0) begin
                                state <= S_RD_BUF;
                            end else begin
                                wb_kind <= WB_OK;
                                state   <= cur_last ? S_WB : S_RD_STAT;
                            end
                        end
                    end
                    S_WB: if (mem_ack) begin
                        in_frame <= 1'b0;
                        uf_q     <= 1'b0;
                        state    <= (wb_kind == WB_OK) ? S_RD_STAT : S_IDLE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    txd_qptr #(.AW(AW), .STEP(DESC_B)) u_qptr (
        .clk    (clk),
        .rst    (rst),
        .base   (q_base),
        .reload (ptr_reload),
        .step   (buf_done),
        .wrap   (wrap_q),
        .ptr    (ptr)
    );

    txd_ser #(.NB(NB), .CW(CW)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .load     ((state == S_RD_BUF) && mem_ack && !abort && !dis),
        .word     (mem_rdata),
        .count    (take),
        .pop      (fire),
        .flush    (dis || ((state == S_SEND) && abort)),
        .byte_o   (ser_byte),
        .avail    (ser_avail),
        .last_one (ser_last)
    );

    txd_done u_done (
        .clk  (clk),
        .rst  (rst),
        .set  (wb_ok_ack),
        .clr  (sts_wr && sts_wdata[STS_DONE]),
        .done (done)
    );

    always_comb begin
        sts_rdata           = '0;
        sts_rdata[STS_DONE] = done;
    end

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !dis) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(mem_req && mem_we && mem_ack));

    // R11
    ptr_base_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(en_q) |=> (ptr == q_base));

    // R11
    valid_en_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> en_q);

    // R9
    undr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        uf_q |-> !tx_valid);

endmodule

// File: tb/tx_desc_engine_tb.sv
module tx_desc_engine_tb;
    localparam int DBASE = 32'h100;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] q_base = DBASE;
    logic        sts_wr = 1'b0;
    logic [31:0] sts_wdata = '0;
    logic [31:0] sts_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_sof, tx_eof;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        mac_underrun = 1'b0;

    always #10 clk = ~clk;

    tx_desc_engine u_dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .q_base(q_base),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof), .mac_underrun(mac_underrun)
    );

    logic [31:0] mem [0:511];
    logic [9:0]  exp_b [$];
    logic [63:0] exp_w [$];
    int  n_chk = 0, n_bad = 0;
    int  cyc = 0, mptr = 0, ua = -1, fr_bytes = 0;
    int  lat_mode = 0, rdy_mode = 0;
    bit  exp_done = 0, saw_req = 0, running = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit used, input bit wrap, input bit last, input int len);
        return (32'(used) << 31) | (32'(wrap) << 30) | (32'(last) << 15) | (32'(len) & 32'h7FF);
    endfunction

    function automatic int bufa(input int i);
        return 32'h400 + 32'h40 * i;
    endfunction

    task automatic setd(input int idx, input logic [31:0] st);
        mem[(DBASE + 8 * idx) >> 2]     = bufa(idx);
        mem[(DBASE + 8 * idx + 4) >> 2] = st;
    endtask

    // Behavioural reference: walks the ring and lists expected bytes and write-backs
    task automatic model(input int start);
        logic [31:0] mm [0:511];
        logic [31:0] st, fs, ba, w, v;
        int idx, first, tot, len;
        bit inf, stop;
        for (int i = 0; i < 512; i++) mm[i] = mem[i];
        idx = start; inf = 0; first = 0; fs = '0; tot = 0; stop = 0;
        for (int g = 0; g < 64 && !stop; g++) begin
            st = mm[(DBASE + 8 * idx + 4) >> 2];
            if (st[31]) begin
                if (inf) begin
                    v = fs | 32'h8800_0000;
                    exp_w.push_back({32'(DBASE + 8 * first + 4), v});
                    mptr = 0;
                end else begin
                    mptr = idx;
                end
                stop = 1;
            end else begin
                if (!inf) begin inf = 1; first = idx; fs = st; end
                ba  = mm[(DBASE + 8 * idx) >> 2];
                len = int'(st[10:0]);
                for (int k = 0; k < len && !stop; k++) begin
                    w = mm[(ba >> 2) + k / 4];
                    exp_b.push_back({st[15] && (k == len - 1), tot == 0, w[8 * (k % 4) +: 8]});
                    tot++;
                    if (ua >= 0 && tot == ua) begin
                        v = fs | 32'h9000_0000;
                        exp_w.push_back({32'(DBASE + 8 * first + 4), v});
                        mptr = 0;
                        stop = 1;
                    end
                end
                if (!stop) begin
                    if (st[15]) begin
                        v = fs | 32'h8000_0000;
                        exp_w.push_back({32'(DBASE + 8 * first + 4), v});
                        mm[(DBASE + 8 * first + 4) >> 2] = v;
                        exp_done = 1;
                        inf = 0;
                        tot = 0;
                    end
                    idx = st[30] ? 0 : idx + 1;
                end
            end
        end
    endtask

    // Memory, sink and comparison on every clock
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
        if (!rst) begin
            tx_ready     = (rdy_mode == 0) ? 1'b1 : (cyc % 3 != 0);
            mem_ack      = mem_req && ((lat_mode == 0) || (cyc % 2 == 0));
            mem_rdata    = mem[mem_addr[10:2]];
            mac_underrun = (ua >= 0) && (fr_bytes >= ua);
            #1;
            if (mem_req) saw_req = 1;
            if (mem_req && mem_we && mem_ack) begin
                if (exp_w.size() == 0) begin
                    chk(0, "R5", "unexpected write-back", {mem_addr, mem_wdata}, 64'h0);
                end else begin
                    logic [63:0] e;
                    e = exp_w.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R5", "write-back addr/data", {mem_addr, mem_wdata}, e);
                end
                mem[mem_addr[10:2]] = mem_wdata;
            end
            if (tx_valid && tx_ready) begin
                if (exp_b.size() == 0) begin
                    chk(0, "R4", "unexpected byte", {54'h0, tx_eof, tx_sof, tx_data}, 64'h0);
                end else begin
                    logic [9:0] e;
                    e = exp_b.pop_front();
                    chk({tx_eof, tx_sof, tx_data} == e, "R4", "byte eof/sof/data",
                        {54'h0, tx_eof, tx_sof, tx_data}, {54'h0, e});
                end
                fr_bytes++;
            end
        end
    end

    task automatic ctl(input logic [31:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    task automatic sts(input logic [31:0] v);
        @(negedge clk); sts_wr = 1'b1; sts_wdata = v;
        @(negedge clk); sts_wr = 1'b0; sts_wdata = '0;
    endtask

    task automatic run(input int u, input string req);
        ua = u; fr_bytes = 0; exp_done = 0;
        model(mptr);
        ctl(32'h208);
        for (int t = 0; t < 5000 && (exp_b.size() != 0 || exp_w.size() != 0); t++) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(exp_b.size() == 0, req, "bytes left unsent", 64'(exp_b.size()), 64'h0);
        chk(exp_w.size() == 0, req, "write-backs missing", 64'(exp_w.size()), 64'h0);
        chk(sts_rdata[5] == exp_done, req, "done flag", 64'(sts_rdata[5]), 64'(exp_done));
        // R10: a write without bit 5 keeps done, a write with bit 5 clears it
        sts(32'h0000_0010);
        #2 chk(sts_rdata[5] == exp_done, "R10", "done kept on write of 0", 64'(sts_rdata[5]), 64'(exp_done));
        sts(32'h0000_0020);
        #2 chk(sts_rdata == 32'h0, "R10", "done cleared", 64'(sts_rdata), 64'h0);
        ua = -1;
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = (32'h9E37_79B9 * 32'(i)) ^ 32'h5A5A_0F0F;
        for (int i = 0; i < 8; i++) setd(i, mk(1, 0, 0, 0));
        rst = 1'b1;
        repeat (4) @(negedge clk);
        #2;
        // R1
        chk(!mem_req && !tx_valid && sts_rdata == 0, "R1", "reset outputs",
            {62'h0, mem_req, tx_valid}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        #2 chk(!mem_req && !tx_valid && sts_rdata == 0, "R1", "after reset release",
               {31'h0, mem_req, sts_rdata}, 64'h0);

        // R3: start while disabled does nothing
        saw_req = 0;
        ctl(32'h200);
        repeat (20) @(negedge clk);
        chk(!saw_req, "R3", "request after start while disabled", 64'(saw_req), 64'h0);
        ctl(32'h008);

        // R2 R4 R5 R6: single buffer partial word
        setd(0, mk(0, 0, 1, 7));
        run(-1, "R5");
        chk(mptr == 1, "R6", "model stop position", 64'(mptr), 64'h1);

        // R4 R6: multi-buffer frame, zero-length buffer, back-to-back frames, stalls
        lat_mode = 1; rdy_mode = 1;
        setd(1, mk(0, 0, 0, 5));
        setd(2, mk(0, 0, 0, 0));
        setd(3, mk(0, 0, 1, 9));
        setd(4, mk(0, 0, 1, 4));
        run(-1, "R6");

        // R7: wrap back to base, stop at the already-used descriptor 0
        setd(5, mk(0, 0, 1, 6));
        setd(6, mk(0, 1, 1, 3));
        run(-1, "R7");

        // R8: used descriptor inside a frame
        setd(0, mk(0, 0, 0, 4));
        run(-1, "R8");

        // R9: underrun after 6 bytes of a 10-byte frame
        lat_mode = 0;
        setd(0, mk(0, 0, 1, 10));
        run(6, "R9");

        // R11: clearing enable returns the pointer to the base
        rdy_mode = 0;
        setd(0, mk(0, 0, 1, 3));
        setd(1, mk(0, 0, 1, 2));
        setd(2, mk(1, 0, 0, 0));
        run(-1, "R6");
        ctl(32'h000);
        repeat (3) @(negedge clk);
        ctl(32'h008);
        mptr = 0;
        setd(0, mk(0, 0, 1, 5));
        setd(1, mk(1, 0, 0, 0));
        run(-1, "R11");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule